// File: doc/BRIEF.md
# Set/Clear Control Register

This block holds a 15-bit control word shared by the audio, disk and serial parts of a peripheral chip. Software changes selected bits without a read-modify-write cycle. Each write carries a polarity flag in data bit 15. When the flag is 1, the 1-bits of the data set the matching stored bits. When the flag is 0, the 1-bits of the data clear them. Stored bits whose data bit is 0 keep their value.

The register has two word offsets. Writes go to 0x09E. Reads come from 0x010, which returns the stored word with bit 15 as 0. The stored word also drives decoded control outputs:
- a precompensation code and type,
- a serial break that forces the transmit line low,
- two disk sync enables and a disk rate select,
- four audio period-modulation enables and four audio volume-modulation enables.

Each bus strobe falls into one of four access classes:
- `ACC_IDLE`: no strobe.
- `ACC_WRITE`: a write to 0x09E. The stored word changes at the next clock edge.
- `ACC_READ`: a read of 0x010. Read data is driven combinationally in the same cycle.
- `ACC_DROP`: any other strobe. It has no effect.

The class is recomputed every cycle from the bus inputs, and no state is carried between cycles except the stored word.

Top module: `ctl_setclr_reg`

## Requirements
- R1: While reset is asserted, and after it is released, all stored bits are 0. A read returns 0x0000 and every decoded output is 0.
- R2: A write strobe at word offset 0x09E with data bit 15 = 1 sets, at the next clock edge, every stored bit whose data bit (14:0) is 1.
- R3: A write strobe at 0x09E with data bit 15 = 0 clears, at the next clock edge, every stored bit whose data bit (14:0) is 1.
- R4: On every write, stored bits whose data bit is 0 keep their value. In particular, writing 0x8000 or 0x0000 changes nothing.
- R5: A read strobe at 0x010 drives read data = {1'b0, stored[14:0]} in the same cycle and changes no stored bit. Without a read strobe at 0x010, read data is 0x0000, and bit 15 of read data is always 0.
- R6: Strobes that are neither a write to 0x09E nor a read of 0x010 are ignored. This includes a write to 0x010, a write to any other offset, and a read of 0x09E. Such a read returns 0x0000.
- R7: precomp_code equals stored bits 14:13 (00 none, 01 140 ns, 10 280 ns, 11 560 ns). precomp_mfm equals stored bit 12 (1 = MFM, 0 = GCR).
- R8: ser_break equals stored bit 11. While it is 1, tx_out is 0. Otherwise tx_out equals tx_in.
- R9: sync_word_en equals stored bit 10, sync_msb_en equals stored bit 9, and disk_fast equals stored bit 8.
- R10: mod_period_en[n] equals stored bit 4+n, and mod_volume_en[n] equals stored bit n, for n = 0..3. Index n means audio channel n modulates channel n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_stb | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Word offset |
| reg_wdata | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| reg_rdata | output | 16 | Read data |
| tx_in | input | 1 | Serial transmit line from the transmitter |
| tx_out | output | 1 | Serial transmit line after break forcing |
| precomp_code | output | 2 | Precompensation amount code |
| precomp_mfm | output | 1 | Precompensation type, 1 = MFM |
| ser_break | output | 1 | Serial break active |
| sync_word_en | output | 1 | Disk word-sync enable |
| sync_msb_en | output | 1 | Disk MSB-sync enable |
| disk_fast | output | 1 | Disk data rate select, 1 = fast |
| mod_period_en | output | 4 | Audio period modulation enables |
| mod_volume_en | output | 4 | Audio volume modulation enables |

## Verification
The bench targets the polarity flag. A design that inverts it or ignores it would set bits on a clear write, or the reverse. A write of data bit 15 alone exposes a design that treats the flag as a storable bit: it would read back 0x8000.

Writes of 0x0000 and 0x8000 check that zero data bits are left untouched. A design that assigns instead of masking would wipe the word.

Cross-offset accesses are also covered: a write to the read offset and a read of the write offset. A loose address decoder would corrupt the word or return data on the wrong offset.

Field patterns sweep every precompensation code and alternate the sync, rate and modulation bits. This exposes swapped or shifted field positions. The break test toggles tx_in, which catches a break gate that is missing or inverted.

// File: rtl/ctl_setclr_pkg.sv
package ctl_setclr_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 9;
    localparam logic [ADDR_W-1:0] WR_OFS = 9'h09E;
    localparam logic [ADDR_W-1:0] RD_OFS = 9'h010;
    localparam int AUDIO_CH = 4;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_DROP  = 2'd3
    } acc_e;
endpackage

// File: rtl/ctl_acc_dec.sv
module ctl_acc_dec
    import ctl_setclr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] WR_ADDR = WR_OFS,
    parameter logic [AW-1:0] RD_ADDR = RD_OFS
) (
    input  logic          stb,
    input  logic          we,
    input  logic [AW-1:0] addr,
    output acc_e          acc
);
    always_comb begin
        if (!stb)
            acc = ACC_IDLE;
        else if (we && addr == WR_ADDR)
            acc = ACC_WRITE;
        else if (!we && addr == RD_ADDR)
            acc = ACC_READ;
        else
            acc = ACC_DROP;
    end
endmodule

// File: rtl/ctl_bits_store.sv
module ctl_bits_store #(
    parameter int SW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          set_sel,
    input  logic [SW-1:0] mask,
    output logic [SW-1:0] q
);
    for (genvar b = 0; b < SW; b++) begin : g_bit
        logic nxt;
        always_comb begin
            nxt = q[b];
            if (wr_en && mask[b])
                nxt = set_sel;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[b] <= 1'b0;
            else
                q[b] <= nxt;
        end
    end
endmodule

// File: rtl/ctl_field_map.sv
module ctl_field_map #(
    parameter int SW  = 15,
    parameter int NCH = 4
) (
    input  logic [SW-1:0]  q,
    input  logic           tx_in,
    output logic           tx_out,
    output logic [1:0]     precomp_code,
    output logic           precomp_mfm,
    output logic           ser_break,
    output logic           sync_word_en,
    output logic           sync_msb_en,
    output logic           disk_fast,
    output logic [NCH-1:0] mod_period_en,
    output logic [NCH-1:0] mod_volume_en
);
    localparam int VOL_LSB = 0;
    localparam int PER_LSB = VOL_LSB + NCH;
    localparam int RATE_B  = PER_LSB + NCH;
    localparam int MSBS_B  = RATE_B + 1;
    localparam int WRDS_B  = MSBS_B + 1;
    localparam int BRK_B   = WRDS_B + 1;
    localparam int TYPE_B  = BRK_B + 1;
    localparam int CODE_B  = TYPE_B + 1;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign mod_volume_en[c] = q[VOL_LSB + c];
        assign mod_period_en[c] = q[PER_LSB + c];
    end

    always_comb begin
        disk_fast    = q[RATE_B];
        sync_msb_en  = q[MSBS_B];
        sync_word_en = q[WRDS_B];
        ser_break    = q[BRK_B];
        precomp_mfm  = q[TYPE_B];
        precomp_code = q[CODE_B +: 2];
        tx_out       = tx_in & ~q[BRK_B];
    end
endmodule

// File: rtl/ctl_setclr_reg.sv
module ctl_setclr_reg
    import ctl_setclr_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int NCH = AUDIO_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_stb,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           tx_in,
    output logic           tx_out,
    output logic [1:0]     precomp_code,
    output logic           precomp_mfm,
    output logic           ser_break,
    output logic           sync_word_en,
    output logic           sync_msb_en,
    output logic           disk_fast,
    output logic [NCH-1:0] mod_period_en,
    output logic [NCH-1:0] mod_volume_en
);
    localparam int SW = DW - 1;

    acc_e          acc;
    logic [SW-1:0] ctl_q;
    logic          wr_en;

    ctl_acc_dec #(.AW(AW)) u_dec (
        .stb  (reg_stb),
        .we   (reg_we),
        .addr (reg_addr),
        .acc  (acc)
    );

    assign wr_en = (acc == ACC_WRITE);

    ctl_bits_store #(.SW(SW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .set_sel (reg_wdata[DW-1]),
        .mask    (reg_wdata[SW-1:0]),
        .q       (ctl_q)
    );

    always_comb begin
        unique case (acc)
            ACC_READ:  reg_rdata = {1'b0, ctl_q};
            ACC_IDLE,
            ACC_WRITE,
            ACC_DROP:  reg_rdata = '0;
            default:   reg_rdata = '0;
        endcase
    end

    ctl_field_map #(.SW(SW), .NCH(NCH)) u_map (
        .q             (ctl_q),
        .tx_in         (tx_in),
        .tx_out        (tx_out),
        .precomp_code  (precomp_code),
        .precomp_mfm   (precomp_mfm),
        .ser_break     (ser_break),
        .sync_word_en  (sync_word_en),
        .sync_msb_en   (sync_msb_en),
        .disk_fast     (disk_fast),
        .mod_period_en (mod_period_en),
        .mod_volume_en (mod_volume_en)
    );
endmodule

// File: rtl/ctl_setclr_chk.sv
module ctl_setclr_chk #(
    parameter int DW = 16,
    parameter int AW = 9,
    parameter logic [AW-1:0] WR_ADDR = 9'h09E
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_stb,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          ser_break,
    input logic          tx_out,
    input logic [DW-2:0] ctl_q
);
    logic wr_hit;
    assign wr_hit = reg_stb && reg_we && (reg_addr == WR_ADDR);

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && reg_wdata[DW-1]) |=>
        ((ctl_q & $past(reg_wdata[DW-2:0])) == $past(reg_wdata[DW-2:0])));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !reg_wdata[DW-1]) |=>
        ((ctl_q & $past(reg_wdata[DW-2:0])) == '0));

    // R4
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=>
        ((ctl_q & ~$past(reg_wdata[DW-2:0])) == ($past(ctl_q) & ~$past(reg_wdata[DW-2:0]))));

    // R6
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ctl_q));

    // R5
    rd_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1] == 1'b0);

    // R8
    break_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_break |-> !tx_out);
endmodule

bind ctl_setclr_reg ctl_setclr_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_stb   (reg_stb),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ser_break (ser_break),
    .tx_out    (tx_out),
    .ctl_q     (ctl_q)
);

// File: tb/sim_ctl_setclr_reg.sv
module sim_ctl_setclr_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] WR_A = 9'h09E;
    localparam logic [8:0] RD_A = 9'h010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_stb = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_in = 1'b1;
    logic        tx_out;
    logic [1:0]  precomp_code;
    logic        precomp_mfm, ser_break, sync_word_en, sync_msb_en, disk_fast;
    logic [3:0]  mod_period_en, mod_volume_en;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [15:0] exp_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_setclr_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_stb(reg_stb), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_in(tx_in), .tx_out(tx_out), .precomp_code(precomp_code),
        .precomp_mfm(precomp_mfm), .ser_break(ser_break),
        .sync_word_en(sync_word_en), .sync_msb_en(sync_msb_en),
        .disk_fast(disk_fast), .mod_period_en(mod_period_en),
        .mod_volume_en(mod_volume_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_stb = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_stb = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr(input logic [15:0] d);
        access(1'b1, WR_A, d);
        if (d[15]) exp_q[14:0] = exp_q[14:0] | d[14:0];
        else       exp_q[14:0] = exp_q[14:0] & ~d[14:0];
    endtask

    task automatic rd_at(input logic [8:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_stb = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk);
        #1 reg_stb = 1'b0;
    endtask

    task automatic chk_read(input string req);
        logic [15:0] v;
        rd_at(RD_A, v);
        chk(req, v, exp_q);
    endtask

    task automatic chk_fields();
        #1;
        chk("R7", {precomp_code, precomp_mfm}, {exp_q[14:13], exp_q[12]});
        chk("R8", ser_break, exp_q[11]);
        chk("R9", {sync_word_en, sync_msb_en, disk_fast}, exp_q[10:8]);
        chk("R10", {mod_period_en, mod_volume_en}, exp_q[7:0]);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd_at(RD_A, v);
        chk("R1 in reset", v, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        chk_read("R1 after reset");
        chk_fields();
    endtask

    task automatic t_set();
        wr(16'h8000 | 16'h5A5A);
        chk_read("R2 set pattern");
        wr(16'hFFFF);
        chk_read("R2 set all");
    endtask

    task automatic t_clear();
        wr(16'h0F0F);
        chk_read("R3 clear pattern");
        wr(16'h7FFF);
        chk_read("R3 clear all");
        wr(16'h8000 | 16'h2481);
    endtask

    task automatic t_keep();
        wr(16'h8000);
        chk_read("R4 set-flag only");
        wr(16'h0000);
        chk_read("R4 zero write");
    endtask

    task automatic t_read();
        logic [15:0] v;
        chk_read("R5 first read");
        chk_read("R5 repeated read");
        #1 chk("R5 idle rdata", reg_rdata, 16'h0000);
        wr(16'hFFFF);
        rd_at(RD_A, v);
        chk("R5 bit15 zero", v[15], 1'b0);
        chk("R5 full read", v, 16'h7FFF);
    endtask

    task automatic t_ignore();
        logic [15:0] v;
        wr(16'h7FFF);
        wr(16'h8000 | 16'h1234);
        access(1'b1, RD_A, 16'hFFFF);
        chk_read("R6 write to read offset");
        access(1'b1, 9'h0AA, 16'h7FFF);
        chk_read("R6 write to other offset");
        rd_at(WR_A, v);
        chk("R6 read of write offset", v, 16'h0000);
        chk_read("R6 state after cross reads");
    endtask

    task automatic t_fields();
        for (int k = 0; k < 8; k++) begin
            logic [15:0] p;
            p = {1'b1, k[1:0], k[2], 1'b0, (k % 2 == 0) ? 3'b101 : 3'b010,
                 (k % 2 == 0) ? 8'hA5 : 8'h5A};
            wr(16'h7FFF);
            wr(p);
            chk_fields();
        end
    endtask

    task automatic t_break();
        wr(16'h7FFF);
        wr(16'h8800);
        chk_fields();
        tx_in = 1'b1; #1 chk("R8 tx forced low (in=1)", tx_out, 1'b0);
        tx_in = 1'b0; #1 chk("R8 tx forced low (in=0)", tx_out, 1'b0);
        wr(16'h0800);
        tx_in = 1'b1; #1 chk("R8 tx follows (in=1)", tx_out, 1'b1);
        tx_in = 1'b0; #1 chk("R8 tx follows (in=0)", tx_out, 1'b0);
        tx_in = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_set();
        t_clear();
        t_keep();
        t_read();
        t_ignore();
        t_fields();
        t_break();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule